// File: doc/BRIEF.md
# Conversion Result Validity Tracker

This block sits between the data-ready line of a sigma-delta converter and the interrupt input of a host. After the converter is disturbed, its digital filter needs a number of output periods before it produces settled results. The tracker knows how long each kind of disturbance takes to settle and suppresses data-ready falling edges until that time has passed. Only results that can be trusted reach the host as a one-clock strobe.

Some disturbances are settled by waiting a fixed number of notch periods, measured with an internal timer of `NOTCH_CYC` clock cycles per period. Others are settled by dropping a fixed number of data-ready edges. Background calibration uses both: first a wait, then one dropped edge. A sync pulse resets the converter's filter, so it replaces whatever settling was in progress with a wait of exactly three notch periods.

The controller has three states. `ST_IDLE` forwards every falling edge. `ST_WAIT` runs the notch-period timer. `ST_DISCARD` drops edges while a counter runs down. The transitions are as follows:
- Any accepted event or sync moves the controller to `ST_WAIT`, except an input-side change, which moves it to `ST_DISCARD`.
- When the timer expires, `ST_WAIT` goes to `ST_DISCARD` if discards are pending, and to `ST_IDLE` if none are.
- `ST_DISCARD` returns to `ST_IDLE` on the edge that drops the last pending discard.

Top module: `valtrk_top`

## Requirements
- R1: After reset, `res_valid` and `settle_busy` are low and the controller is idle.
- R2: While idle, a falling edge on `drdy_n` seen at clock edge E produces `res_valid` high for exactly the one cycle after E.
- R3: Event code bit 0 (channel switch) starts a settling wait of 3 notch periods. If the event is sampled at edge L, `settle_busy` is high after edges L through L+3·NOTCH_CYC and low after edge L+3·NOTCH_CYC+1. Falling edges during the wait produce no strobe. The first edge after the wait is passed.
- R4: Event code bit 1 (self-calibration or system offset calibration) starts a wait of 9 notch periods, with the same timing rule as R3.
- R5: Event code bit 2 (full system calibration) starts a wait of 6 notch periods, with the same timing rule as R3.
- R6: Event code bit 3 (background calibration) starts a wait of 6 notch periods. `settle_busy` stays high after the wait ends. The first falling edge after the wait is dropped and clears `settle_busy`. The second falling edge is passed.
- R7: Event code bit 4 (input-side change: input step, notch change, current source toggled) involves no timed wait. It drops the next 3 falling edges, or 4 when `extra_discard` is high at the event. `settle_busy` stays high until the last dropped edge.
- R8: `sync_pulse` starts a wait of exactly 3 notch periods from its own sampling edge and cancels any remaining wait or pending discards. When it coincides with an event, the sync takes precedence.
- R9: An accepted event that arrives during settling restarts settling using its own rule, counted from its own sampling edge.
- R10: An event code with more than one bit set is ignored. The settling in progress continues unchanged, and while idle, edges are still passed.
- R11: A falling edge sampled in the same cycle as an accepted event or a sync gives no strobe.
- R12: `res_valid` is never high for two consecutive cycles and is high only in response to a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drdy_n | input | 1 | Converter data-ready, active low, synchronous to clk |
| evt_code | input | 5 | One-hot disturbance code, sampled each cycle; zero means no event |
| sync_pulse | input | 1 | Filter sync, one cycle wide |
| extra_discard | input | 1 | Selects a fourth dropped edge for input-side changes |
| res_valid | output | 1 | One-cycle strobe for a settled result |
| settle_busy | output | 1 | High while settling is in progress |

## Verification
The hardest situations to reach are the exact cycle at which a timed wait ends, and interruptions partway through settling. Examples are a sync arriving in the middle of an edge-discard sequence, or a new event arriving midway through a nine-period wait. The stimulus records the clock count at the edge that samples each event or sync. It then waits to exactly the computed boundary edge and checks the busy flag on both sides of it. Data-ready pulses are interleaved inside waits and discard sequences, and a scoreboard queue holds the expected strobe outcome of each pulse.

// File: rtl/valtrk_pkg.sv
package valtrk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT    = 2'd1,
        ST_DISCARD = 2'd2
    } vt_state_e;

    localparam int NUM_EV     = 5;
    localparam int EV_CHAN    = 0;
    localparam int EV_SELFCAL = 1;
    localparam int EV_SYSCAL  = 2;
    localparam int EV_BGCAL   = 3;
    localparam int EV_INPUT   = 4;

    localparam int PER_W  = 4;
    localparam int DISC_W = 3;

    localparam logic [PER_W-1:0]  PER_CHAN    = 4'd3;
    localparam logic [PER_W-1:0]  PER_SELFCAL = 4'd9;
    localparam logic [PER_W-1:0]  PER_SYSCAL  = 4'd6;
    localparam logic [PER_W-1:0]  PER_BGCAL   = 4'd6;
    localparam logic [PER_W-1:0]  PER_SYNC    = 4'd3;
    localparam logic [DISC_W-1:0] DISC_BGCAL  = 3'd1;
    localparam logic [DISC_W-1:0] DISC_INPUT  = 3'd3;

endpackage

// File: rtl/valtrk_edge.sv
module valtrk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sig_n;
    end

    assign fall = prev_q & ~sig_n;
endmodule

// File: rtl/valtrk_timer.sv
module valtrk_timer #(
    parameter int NOTCH_CYC = 16,
    parameter int PER_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PER_W-1:0] periods,
    output logic             expired
);
    localparam int CYC_W = (NOTCH_CYC > 2) ? $clog2(NOTCH_CYC) : 1;
    localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(NOTCH_CYC - 1);

    logic [CYC_W-1:0] cyc_q;
    logic [PER_W-1:0] per_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            per_q <= '0;
        end else if (load) begin
            cyc_q <= CYC_TOP;
            per_q <= periods;
        end else if (per_q != '0) begin
            if (cyc_q == '0) begin
                cyc_q <= CYC_TOP;
                per_q <= per_q - 1'b1;
            end else begin
                cyc_q <= cyc_q - 1'b1;
            end
        end
    end

    assign expired = (per_q == '0);
endmodule

// File: rtl/valtrk_ctrl.sv
module valtrk_ctrl
    import valtrk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall,
    input  logic [NUM_EV-1:0]   evt_code,
    input  logic                sync_pulse,
    input  logic                extra_discard,
    input  logic                expired,
    output logic                tmr_load,
    output logic [PER_W-1:0]    tmr_periods,
    output logic                res_valid,
    output logic                settle_busy
);
    vt_state_e         st_q, st_nxt;
    logic [DISC_W-1:0] disc_q, disc_nxt;
    logic              evt_ok;
    logic              valid_d;
    logic              valid_q;

    assign evt_ok = $onehot(evt_code);

    always_comb begin
        st_nxt      = st_q;
        disc_nxt    = disc_q;
        tmr_load    = 1'b0;
        tmr_periods = '0;
        if (sync_pulse) begin
            tmr_load    = 1'b1;
            tmr_periods = PER_SYNC;
            disc_nxt    = '0;
            st_nxt      = ST_WAIT;
        end else if (evt_ok) begin
            if (evt_code[EV_INPUT]) begin
                disc_nxt = DISC_INPUT + DISC_W'(extra_discard);
                st_nxt   = ST_DISCARD;
            end else begin
                tmr_load = 1'b1;
                st_nxt   = ST_WAIT;
                disc_nxt = '0;
                if (evt_code[EV_CHAN])         tmr_periods = PER_CHAN;
                else if (evt_code[EV_SELFCAL]) tmr_periods = PER_SELFCAL;
                else if (evt_code[EV_SYSCAL])  tmr_periods = PER_SYSCAL;
                else begin
                    tmr_periods = PER_BGCAL;
                    disc_nxt    = DISC_BGCAL;
                end
            end
        end else begin
            unique case (st_q)
                ST_IDLE: st_nxt = ST_IDLE;
                ST_WAIT: begin
                    if (expired)
                        st_nxt = (disc_q != '0) ? ST_DISCARD : ST_IDLE;
                end
                ST_DISCARD: begin
                    if (fall) begin
                        disc_nxt = disc_q - 1'b1;
                        if (disc_q <= DISC_W'(1)) begin
                            disc_nxt = '0;
                            st_nxt   = ST_IDLE;
                        end
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    assign valid_d = (st_q == ST_IDLE) && fall && !sync_pulse && !evt_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            disc_q <= '0;
        end else begin
            st_q   <= st_nxt;
            disc_q <= disc_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
    end

    assign res_valid   = valid_q;
    assign settle_busy = (st_q != ST_IDLE);
endmodule

// File: rtl/valtrk_top.sv
module valtrk_top
    import valtrk_pkg::*;
#(
    parameter int NOTCH_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drdy_n,
    input  logic [NUM_EV-1:0] evt_code,
    input  logic              sync_pulse,
    input  logic              extra_discard,
    output logic              res_valid,
    output logic              settle_busy
);
    logic             fall;
    logic             expired;
    logic             tmr_load;
    logic [PER_W-1:0] tmr_periods;

    valtrk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_n (drdy_n),
        .fall  (fall)
    );

    valtrk_timer #(
        .NOTCH_CYC (NOTCH_CYC),
        .PER_W     (PER_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .periods (tmr_periods),
        .expired (expired)
    );

    valtrk_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .fall          (fall),
        .evt_code      (evt_code),
        .sync_pulse    (sync_pulse),
        .extra_discard (extra_discard),
        .expired       (expired),
        .tmr_load      (tmr_load),
        .tmr_periods   (tmr_periods),
        .res_valid     (res_valid),
        .settle_busy   (settle_busy)
    );
endmodule

// File: rtl/valtrk_chk.sv
module valtrk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       drdy_n,
    input logic [4:0] evt_code,
    input logic       sync_pulse,
    input logic       res_valid,
    input logic       settle_busy
);
    p_single_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_strobe_from_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!$past(drdy_n) && $past(drdy_n, 2)));

    p_idle_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!settle_busy && $fell(drdy_n) && evt_code == '0 && !sync_pulse) |=> res_valid);

    p_event_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(evt_code) |=> settle_busy);

    p_sync_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> settle_busy);

    p_event_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(evt_code) || sync_pulse) |=> !res_valid);
endmodule

bind valtrk_top valtrk_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drdy_n      (drdy_n),
    .evt_code    (evt_code),
    .sync_pulse  (sync_pulse),
    .res_valid   (res_valid),
    .settle_busy (settle_busy)
);

// File: tb/tb_valtrk_top.sv
`timescale 1ns/1ps
module tb_valtrk_top;
    localparam int NC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       drdy_n = 1'b1;
    logic [4:0] evt_code = '0;
    logic       sync_pulse = 1'b0;
    logic       extra_discard = 1'b0;
    logic       res_valid;
    logic       settle_busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = 0;
    bit done = 1'b0;

    int    due_q[$];
    bit    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    valtrk_top #(.NOTCH_CYC(NC)) dut (
        .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .evt_code(evt_code),
        .sync_pulse(sync_pulse), .extra_discard(extra_discard),
        .res_valid(res_valid), .settle_busy(settle_busy)
    );

    // Scoreboard monitor
    always @(negedge clk) begin
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            checks++;
            if (res_valid !== exp_q[0]) begin
                errors++;
                $display("FAIL %s: res_valid=%0b expected=%0b at cycle %0d",
                         tag_q[0], res_valid, exp_q[0], cyc);
            end
            void'(due_q.pop_front());
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end else if (rst_n && res_valid) begin
            checks++;
            errors++;
            $display("FAIL R12: res_valid=1 expected=0 (no edge due) at cycle %0d", cyc);
        end
    end

    task automatic chk(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, expv, cyc);
        end
    endtask

    task automatic pulse_evt(input logic [4:0] code, input bit sy,
                             input bit expv, input string tag);
        @(negedge clk);
        drdy_n = 1'b0;
        evt_code = code;
        sync_pulse = sy;
        due_q.push_back(cyc + 1);
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(negedge clk);
        if (code != 5'd0 || sy) t0 = cyc;
        evt_code = '0;
        sync_pulse = 1'b0;
        @(negedge clk);
        drdy_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input bit expv, input string tag);
        pulse_evt(5'd0, 1'b0, expv, tag);
    endtask

    task automatic fire(input logic [4:0] code, input bit sy);
        @(negedge clk);
        evt_code = code;
        sync_pulse = sy;
        @(negedge clk);
        t0 = cyc;
        evt_code = '0;
        sync_pulse = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic boundary(input int n, input string tag);
        wait_until(t0 + n * NC);
        chk(tag, settle_busy, 1'b1);
        @(negedge clk);
        chk(tag, settle_busy, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", res_valid, 1'b0);
        chk("R1", settle_busy, 1'b0);

        // R2 idle forwarding
        pulse(1'b1, "R2");
        pulse(1'b1, "R2");

        // R3 channel switch: 3 periods
        fire(5'b00001, 1'b0);
        pulse(1'b0, "R3");
        boundary(3, "R3");
        pulse(1'b1, "R3");

        // R4 self calibration: 9 periods
        fire(5'b00010, 1'b0);
        pulse(1'b0, "R4");
        pulse(1'b0, "R4");
        boundary(9, "R4");
        pulse(1'b1, "R4");

        // R5 system calibration: 6 periods
        fire(5'b00100, 1'b0);
        pulse(1'b0, "R5");
        boundary(6, "R5");
        pulse(1'b1, "R5");

        // R6 background calibration: 6 periods then one dropped edge
        fire(5'b01000, 1'b0);
        wait_until(t0 + 6 * NC + 2);
        chk("R6", settle_busy, 1'b1);
        pulse(1'b0, "R6");
        chk("R6", settle_busy, 1'b0);
        pulse(1'b1, "R6");

        // R7 input change: 3 drops, then 4 drops with extra
        extra_discard = 1'b0;
        fire(5'b10000, 1'b0);
        pulse(1'b0, "R7");
        pulse(1'b0, "R7");
        chk("R7", settle_busy, 1'b1);
        pulse(1'b0, "R7");
        chk("R7", settle_busy, 1'b0);
        pulse(1'b1, "R7");
        extra_discard = 1'b1;
        fire(5'b10000, 1'b0);
        extra_discard = 1'b0;
        pulse(1'b0, "R7");
        pulse(1'b0, "R7");
        pulse(1'b0, "R7");
        chk("R7", settle_busy, 1'b1);
        pulse(1'b0, "R7");
        pulse(1'b1, "R7");

        // R8 sync in the middle of a discard sequence
        fire(5'b10000, 1'b0);
        pulse(1'b0, "R8");
        fire(5'b00000, 1'b1);
        boundary(3, "R8");
        pulse(1'b1, "R8");
        // R8 sync with a 9-period event in the same cycle: sync wins
        fire(5'b00010, 1'b1);
        boundary(3, "R8");
        pulse(1'b1, "R8");

        // R9 restart: self-cal then channel switch two periods in
        fire(5'b00010, 1'b0);
        wait_until(t0 + 2 * NC);
        fire(5'b00001, 1'b0);
        boundary(3, "R9");
        pulse(1'b1, "R9");

        // R10 multi-bit code ignored while idle and during a wait
        fire(5'b00011, 1'b0);
        chk("R10", settle_busy, 1'b0);
        pulse(1'b1, "R10");
        fire(5'b00001, 1'b0);
        @(negedge clk);
        evt_code = 5'b10100;
        @(negedge clk);
        evt_code = '0;
        boundary(3, "R10");

        // R11 event coinciding with a falling edge
        pulse_evt(5'b00001, 1'b0, 1'b0, "R11");
        boundary(3, "R11");
        pulse_evt(5'b00000, 1'b1, 1'b0, "R11");
        boundary(3, "R11");
        pulse(1'b1, "R11");

        repeat (4) @(negedge clk);
        if (due_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R12: %0d expected strobes never checked, expected 0", due_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule